// File: doc/BRIEF.md
# Interleaved Block-Refill Controller

After a cache miss this block fetches one four-word cache block from a behavioural main memory of four word-wide banks. It takes a block address on a single-cycle request and spends one cycle sending that address. It then waits out the bank access latency and streams the block back to the cache, one beat at a time, with a valid strobe, a word index and a done strobe on the final beat.

A build parameter selects the memory organisation, so the refill penalties of the four layouts can be compared. In the interleaved layout, consecutive words of a block sit in consecutive banks. All four bank accesses therefore overlap, and the words then leave one per cycle over a one-word bus. In the one-, two- and four-word-wide layouts, each bus beat needs its own full bank access. The block always arrives whole, starting at word 0, whatever word offset the request address carries.

Top module: `interleave_refill`

## Requirements
- R1: After reset, busy, rdValid and done are all low.
- R2: A request is accepted only while busy is low. A request raised while busy is high has no effect on the block being returned or on the following idle period.
- R3: Counting the cycle after the accepting clock edge as cycle 1, busy is high for exactly the penalty of the selected layout and is low in the next cycle.
- R4: In the interleaved layout (ORG=3) the penalty is 20 cycles: the address takes 1 cycle, one 15-cycle access is shared by all four banks, and words 0 to 3 appear in cycles 17, 18, 19 and 20.
- R5: In the one-word-wide layout (ORG=0) the penalty is 65 cycles: word n appears in cycle 17+16n.
- R6: In the two-word-wide layout (ORG=1) the penalty is 33 cycles: words 0-1 appear in cycle 17 and words 2-3 in cycle 33.
- R7: In the four-word-wide layout (ORG=2) the penalty is 17 cycles, and the whole block appears in cycle 17.
- R8: Memory word at word address w (0 to 4*ROWS-1) holds (w*32'h01000193) ^ 32'hC3A55A3C. The block row is reqAddr[9:4]. On a beat, lane j (rdData bits 32j+31 to 32j) carries block word rdIdx+j.
- R9: reqAddr[3:0] and the bits above reqAddr[9] are ignored. The first beat is always word 0 of the row.
- R10: done is high only in the cycle of the final beat, which carries rdIdx = 4 - beat width.
- R11: rdValid is high only in the beat cycles listed for the layout, and rdIdx is a multiple of the beat width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Miss request strobe |
| reqAddr | input | ADDR_W | Byte address of the missing block |
| busy | output | 1 | Refill in progress |
| rdValid | output | 1 | Beat valid |
| rdIdx | output | 2 | Index of the block word on lane 0 |
| rdData | output | BEAT_W*DATA_W | Beat data, lane 0 in the low bits |
| done | output | 1 | Final beat of the block |

## Verification
Every result depends on the number of cycles since the accepting edge. For each of the four layouts, the bench keeps its own count of busy cycles and samples on the falling edge. In each cycle it predicts whether a beat, which word index, which data and whether done is due, using the timing in R4 to R7. When busy falls, it compares the total count against the penalty. A stray request is driven a few cycles into a refill, so any wrong acceptance shows up as wrong data or an extra busy period.

// File: rtl/refill_pkg.sv
package refill_pkg;
  localparam int ORG_SERIAL = 0;
  localparam int ORG_DUAL = 1;
  localparam int ORG_QUAD = 2;
  localparam int ORG_INTERLEAVED = 3;
  localparam int BLOCK_WORDS = 4;

  typedef struct packed {
    logic       latchAddr;
    logic       active;
    logic       beatValid;
    logic [1:0] beatIdx;
    logic       lastBeat;
  } refill_strobe_t;

  function automatic int beatWords(input int org);
    case (org)
      ORG_DUAL: return 2;
      ORG_QUAD: return 4;
      default:  return 1;
    endcase
  endfunction

  function automatic logic [31:0] fillWord(input logic [31:0] wordAddr);
    return (wordAddr * 32'h01000193) ^ 32'hC3A55A3C;
  endfunction
endpackage

// File: rtl/refill_ctrl.sv
module refill_ctrl
  import refill_pkg::*;
#(
  parameter int ORG = ORG_INTERLEAVED,
  parameter int ACCESS_CYC = 15
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           reqValid,
  output refill_strobe_t strobe,
  output logic           busy
);
  localparam int BEAT_W = beatWords(ORG);
  localparam int NUM_BEATS = BLOCK_WORDS / BEAT_W;
  localparam bit OVERLAP = (ORG == ORG_INTERLEAVED);
  localparam int PENALTY = OVERLAP ? (1 + ACCESS_CYC + BLOCK_WORDS)
                                   : (1 + NUM_BEATS * (ACCESS_CYC + 1));
  localparam int CNT_W = $clog2(ACCESS_CYC + 1);
  localparam int SHIFT = $clog2(BEAT_W);
  localparam logic [1:0] LAST_BEAT = 2'(NUM_BEATS - 1);
  localparam logic [CNT_W-1:0] LAST_WAIT = CNT_W'(ACCESS_CYC - 1);
  localparam int PEN_W = $clog2(PENALTY + 1) + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_ACCESS, ST_XFER} state_t;

  state_t           state;
  logic [CNT_W-1:0] waitCnt;
  logic [1:0]       beat;
  logic             accept;

  assign accept = reqValid && (state == ST_IDLE);
  assign busy   = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      beat    <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) state <= ST_ADDR;
        ST_ADDR: begin
          state   <= ST_ACCESS;
          waitCnt <= '0;
          beat    <= '0;
        end
        ST_ACCESS: begin
          if (waitCnt == LAST_WAIT) state <= ST_XFER;
          else waitCnt <= waitCnt + 1'b1;
        end
        ST_XFER: begin
          if (beat == LAST_BEAT) begin
            state <= ST_IDLE;
          end else begin
            beat <= beat + 1'b1;
            if (!OVERLAP) begin
              state   <= ST_ACCESS;
              waitCnt <= '0;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.latchAddr = accept;
    strobe.active    = busy;
    strobe.beatValid = (state == ST_XFER);
    strobe.beatIdx   = 2'(beat << SHIFT);
    strobe.lastBeat  = (state == ST_XFER) && (beat == LAST_BEAT);
  end

  logic [PEN_W-1:0] penCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) penCnt <= '0;
    else if (accept) penCnt <= PEN_W'(1);
    else if (busy) penCnt <= penCnt + 1'b1;
  end

  // R3, R4, R5, R6, R7: final beat falls exactly on the layout penalty
  a_r3_penalty_window: assert property (@(posedge clk) disable iff (!rstN)
    strobe.lastBeat |-> penCnt == PEN_W'(PENALTY));
  // R3: idle right after the final beat
  a_r3_idle_after_done: assert property (@(posedge clk) disable iff (!rstN)
    strobe.lastBeat |=> !busy);
  // R2: an accepted request makes the block busy
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy) |=> busy);
endmodule

// File: rtl/refill_dpath.sv
module refill_dpath
  import refill_pkg::*;
#(
  parameter int ORG = ORG_INTERLEAVED,
  parameter int ROWS = 64,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  refill_strobe_t                      strobe,
  input  logic [ADDR_W-1:0]                   reqAddr,
  output logic                                rdValid,
  output logic [1:0]                          rdIdx,
  output logic [beatWords(ORG)*DATA_W-1:0]    rdData,
  output logic                                done
);
  localparam int BEAT_W = beatWords(ORG);
  localparam int ROW_W = $clog2(ROWS);
  localparam int OFS = $clog2(DATA_W / 8) + $clog2(BLOCK_WORDS);

  logic [ROW_W-1:0]  rowReg;
  logic [DATA_W-1:0] bankOut [BLOCK_WORDS];
  logic              unusedAddr;

  assign unusedAddr = ^{reqAddr[ADDR_W-1:ROW_W+OFS], reqAddr[OFS-1:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rowReg <= '0;
    else if (strobe.latchAddr) rowReg <= reqAddr[ROW_W+OFS-1:OFS];
  end

  for (genvar b = 0; b < BLOCK_WORDS; b++) begin : g_bank
    logic [DATA_W-1:0] store [ROWS];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int r = 0; r < ROWS; r++)
          store[r] <= DATA_W'(fillWord(32'(r * BLOCK_WORDS + b)));
      end
    end
    assign bankOut[b] = store[rowReg];
  end

  for (genvar j = 0; j < BEAT_W; j++) begin : g_lane
    assign rdData[j*DATA_W +: DATA_W] = bankOut[strobe.beatIdx + 2'(j)];
  end

  assign rdValid = strobe.beatValid;
  assign rdIdx   = strobe.beatIdx;
  assign done    = strobe.lastBeat;

  // R2: the latched row never moves during a refill
  a_r2_row_held: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.active && !strobe.lastBeat) |=> $stable(rowReg));
  // R10: done only together with a beat
  a_r10_done_with_beat: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (rdValid && rdIdx == 2'(BLOCK_WORDS - BEAT_W)));
  // R11: beats only while busy, indices aligned to the beat width
  a_r11_beat_aligned: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> (strobe.active && (int'(rdIdx) % BEAT_W) == 0));
endmodule

// File: rtl/interleave_refill.sv
module interleave_refill
  import refill_pkg::*;
#(
  parameter int ORG = ORG_INTERLEAVED,
  parameter int ACCESS_CYC = 15,
  parameter int ROWS = 64,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             reqValid,
  input  logic [ADDR_W-1:0]                reqAddr,
  output logic                             busy,
  output logic                             rdValid,
  output logic [1:0]                       rdIdx,
  output logic [beatWords(ORG)*DATA_W-1:0] rdData,
  output logic                             done
);
  refill_strobe_t strobe;

  refill_ctrl #(.ORG(ORG), .ACCESS_CYC(ACCESS_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .strobe(strobe), .busy(busy)
  );

  refill_dpath #(.ORG(ORG), .ROWS(ROWS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .rdValid(rdValid), .rdIdx(rdIdx), .rdData(rdData), .done(done)
  );

  // R1: quiet outputs while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!rdValid && !done));
endmodule

// File: tb/sim_interleave_refill.sv
module sim_interleave_refill;
  localparam int CLK_PERIOD = 10;
  localparam int ACC = 15;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [31:0] reqAddr = '0;

  logic busy [4];
  logic vld [4];
  logic dn [4];
  logic [1:0] idx [4];
  logic [31:0] d0, d1;
  logic [63:0] d2;
  logic [127:0] d3;

  int checks = 0;
  int fails = 0;
  int cyc [4] = '{0, 0, 0, 0};
  logic [5:0] expRow = '0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // mode index m: 0 interleaved, 1 one-word, 2 two-word, 3 four-word
  interleave_refill #(.ORG(3)) u0 (.clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .busy(busy[0]), .rdValid(vld[0]), .rdIdx(idx[0]), .rdData(d0), .done(dn[0]));
  interleave_refill #(.ORG(0)) u1 (.clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .busy(busy[1]), .rdValid(vld[1]), .rdIdx(idx[1]), .rdData(d1), .done(dn[1]));
  interleave_refill #(.ORG(1)) u2 (.clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .busy(busy[2]), .rdValid(vld[2]), .rdIdx(idx[2]), .rdData(d2), .done(dn[2]));
  interleave_refill #(.ORG(2)) u3 (.clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .busy(busy[3]), .rdValid(vld[3]), .rdIdx(idx[3]), .rdData(d3), .done(dn[3]));

  function automatic int bwOf(input int m);
    return (m == 2) ? 2 : (m == 3) ? 4 : 1;
  endfunction

  function automatic int penOf(input int m);
    if (m == 0) return 1 + ACC + 4;
    return 1 + (4 / bwOf(m)) * (ACC + 1);
  endfunction

  function automatic string tagOf(input int m);
    case (m)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      default: return "R7";
    endcase
  endfunction

  // returns beat number due in cycle k, or -1
  function automatic int beatAt(input int m, input int k);
    if (m == 0) return (k >= ACC + 2 && k <= ACC + 5) ? k - (ACC + 2) : -1;
    if (k > 1 && ((k - 1) % (ACC + 1)) == 0 && ((k - 1) / (ACC + 1)) <= 4 / bwOf(m))
      return (k - 1) / (ACC + 1) - 1;
    return -1;
  endfunction

  function automatic logic [31:0] refWord(input int w);
    logic [31:0] wa = 32'(w);
    return (wa * 32'h01000193) ^ 32'hC3A55A3C;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic monitor(input int m, input logic b, input logic v, input logic d,
                         input logic [1:0] ix, input logic [127:0] data);
    int k, n, pen, bw;
    pen = penOf(m);
    bw = bwOf(m);
    if (b) begin
      cyc[m]++;
      k = cyc[m];
      n = beatAt(m, k);
      check(v == (n >= 0), (n >= 0) ? tagOf(m) : "R11", "rdValid timing", v, n >= 0);
      check(d == (k == pen), "R10", "done timing", d, k == pen);
      check(k <= pen, "R3", "busy too long", k, pen);
      if (v && n >= 0) begin
        check(ix == 2'(n * bw), "R9", "word index", ix, n * bw);
        for (int j = 0; j < bw; j++)
          check(data[j*32 +: 32] == refWord(int'(expRow) * 4 + n * bw + j), "R8",
                "lane data", data[j*32 +: 32], refWord(int'(expRow) * 4 + n * bw + j));
      end
    end else begin
      if (cyc[m] != 0) begin
        check(cyc[m] == pen, "R3", "busy length", cyc[m], pen);
        cyc[m] = 0;
      end
      check(!v && !d, "R11", "idle strobes", {v, d}, 0);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      monitor(0, busy[0], vld[0], dn[0], idx[0], 128'(d0));
      monitor(1, busy[1], vld[1], dn[1], idx[1], 128'(d1));
      monitor(2, busy[2], vld[2], dn[2], idx[2], 128'(d2));
      monitor(3, busy[3], vld[3], dn[3], idx[3], 128'(d3));
    end
  end

  task automatic finishRun();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // R2: optional stray request some cycles into the refill
  task automatic refill(input logic [31:0] addr, input bit stray);
    @(negedge clk);
    reqValid = 1'b1;
    reqAddr = addr;
    expRow = addr[9:4];
    @(negedge clk);
    reqValid = 1'b0;
    if (stray) begin
      repeat (4) @(negedge clk);
      reqValid = 1'b1;
      reqAddr = ~addr;
      repeat (2) @(negedge clk);
      reqValid = 1'b0;
    end
    while (busy[0] || busy[1] || busy[2] || busy[3]) @(negedge clk);
    @(negedge clk);
    check(!busy[0] && !busy[1] && !busy[2] && !busy[3], "R2", "stays idle after refill",
          {busy[0], busy[1], busy[2], busy[3]}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    for (int m = 0; m < 4; m++)
      check(!busy[m] && !vld[m] && !dn[m], "R1", "state in reset", {busy[m], vld[m], dn[m]}, 0);
    rstN = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 4; m++)
      check(!busy[m] && !vld[m] && !dn[m], "R1", "state after reset", {busy[m], vld[m], dn[m]}, 0);
    refill(32'h0000_0000, 1'b1);
    refill(32'h0000_03FF, 1'b0);   // R9: nonzero offset, top row
    refill(32'hFFFF_F01C, 1'b1);   // R9: high bits and offset ignored
    refill(32'h0000_0124, 1'b0);
    for (int t = 0; t < 20; t++)
      refill($urandom, ($urandom % 3) == 0);
    finishRun();
  end
endmodule